// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is a vector integer multiply-accumulate engine for neural-network inference. Each operation takes two source vectors and an accumulator vector. All three are split into 32-bit lanes. In every lane the block multiplies small groups of narrow elements, adds the products together, and folds that sum into the lane's 32-bit accumulator value. All of this happens in one fused step.

A per-operation mode input selects the element format. In byte mode, four unsigned bytes are multiplied by four signed bytes. In halfword mode, two pairs of signed 16-bit values are multiplied. With the default of 16 lanes the vector is 512 bits wide. That gives 64 multiply-accumulates per operation in byte mode and 32 in halfword mode.

Operations enter through a valid/ready handshake and leave through another. The pipeline has two stages. When the consumer stalls, the whole pipeline freezes in place.

Top module: `vec_dot_acc`

## Requirements
- R1: While reset is held and right after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: With `in_mode`=0 (byte mode), each lane's result is the accumulator plus the sum over k=0..3 of the unsigned byte at lane bits 8k+7:8k of `src_a` times the signed byte at the same bits of `src_b`.
- R3: With `in_mode`=1 (halfword mode), each lane's result is the accumulator plus the sum over k=0..1 of the signed 16-bit `src_a` element at lane bits 16k+15:16k times the signed `src_b` element at the same bits.
- R4: No partial sum is clipped. Byte 255 times byte -128 in all four slots adds exactly -130560. Halfword -32768 times -32768 in both slots adds exactly 2^31 before the final wrap.
- R5: The final 32-bit addition wraps modulo 2^32 in two's complement and never saturates.
- R6: Lane i occupies bits 32i+31:32i of every vector, and lanes do not affect one another.
- R7: With `out_ready` held at 1, an operation accepted in cycle N appears on `out_result` with `out_valid`=1 in cycle N+2. A new operation can be accepted every cycle.
- R8: While `out_valid`=1 and `out_ready`=0, `out_result` stays stable, `out_valid` stays 1 and `in_ready` is 0. Results leave in acceptance order, with none lost and none duplicated.
- R9: The mode is captured with each operation, so back-to-back operations in different modes each give their own correct result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The block can take an operation this cycle |
| in_mode | input | 1 | 0: unsigned byte by signed byte, 1: signed halfword by signed halfword |
| src_a | input | 32*LANES | First source vector (the unsigned operand in byte mode) |
| src_b | input | 32*LANES | Second source vector (always signed) |
| acc_in | input | 32*LANES | Accumulator vector |
| out_valid | output | 1 | A result is present |
| out_ready | input | 1 | The consumer takes the result |
| out_result | output | 32*LANES | Accumulated result vector |

## Verification
A result is due two cycles after the cycle in which its operation is accepted, as long as `out_ready` stays high. The bench records the cycle number of every accepted operation and compares it with the cycle in which the matching result is observed. Under random back-pressure the latency is not fixed, so the bench checks only order and value. In every stalled cycle it also checks that the output held still and `in_ready` stayed low. Inputs and outputs are both examined one time unit after the falling edge, when all values for the next rising edge are settled.

// File: rtl/vdp_pkg.sv
package vdp_pkg;
    localparam int unsigned LANE_W   = 32;
    localparam int unsigned BYTES    = LANE_W / 8;
    localparam int unsigned HALVES   = LANE_W / 16;
    localparam int unsigned BPROD_W  = 17;
    localparam int unsigned HPROD_W  = 33;
    localparam int unsigned DOT_W    = LANE_W + 2;

    typedef enum logic {
        MODE_U8S8   = 1'b0,
        MODE_S16S16 = 1'b1
    } dp_mode_e;
endpackage

// File: rtl/vdp_lane_dot.sv
module vdp_lane_dot
    import vdp_pkg::*;
(
    input  logic                    mode,
    input  logic [LANE_W-1:0]       op_a,
    input  logic [LANE_W-1:0]       op_b,
    output logic signed [DOT_W-1:0] dot
);
    logic signed [BPROD_W-1:0] bprod [BYTES];
    logic signed [HPROD_W-1:0] hprod [HALVES];

    for (genvar k = 0; k < BYTES; k++) begin : g_byte
        logic signed [BPROD_W-1:0] ua;
        logic signed [BPROD_W-1:0] sb;
        always_comb begin
            ua       = $signed({{(BPROD_W-8){1'b0}}, op_a[8*k +: 8]});
            sb       = $signed({{(BPROD_W-8){op_b[8*k+7]}}, op_b[8*k +: 8]});
            bprod[k] = ua * sb;
        end
    end

    for (genvar k = 0; k < HALVES; k++) begin : g_half
        logic signed [HPROD_W-1:0] sa;
        logic signed [HPROD_W-1:0] sb;
        always_comb begin
            sa       = $signed({{(HPROD_W-16){op_a[16*k+15]}}, op_a[16*k +: 16]});
            sb       = $signed({{(HPROD_W-16){op_b[16*k+15]}}, op_b[16*k +: 16]});
            hprod[k] = sa * sb;
        end
    end

    logic signed [DOT_W-1:0] bsum;
    logic signed [DOT_W-1:0] hsum;

    always_comb begin
        bsum = '0;
        for (int k = 0; k < int'(BYTES); k++) begin
            bsum = bsum + DOT_W'(bprod[k]);
        end
        hsum = '0;
        for (int k = 0; k < int'(HALVES); k++) begin
            hsum = hsum + DOT_W'(hprod[k]);
        end
        dot = (dp_mode_e'(mode) == MODE_S16S16) ? hsum : bsum;
    end
endmodule

// File: rtl/vdp_pipe_ctrl.sv
module vdp_pipe_ctrl (
    input  logic in_valid,
    input  logic out_ready,
    input  logic s1_vld_q,
    input  logic out_vld_q,
    output logic advance,
    output logic take,
    output logic s1_vld_d,
    output logic out_vld_d
);
    always_comb begin
        advance   = !out_vld_q || out_ready;
        take      = advance && in_valid;
        s1_vld_d  = advance ? in_valid : s1_vld_q;
        out_vld_d = advance ? s1_vld_q : out_vld_q;
    end
endmodule

// File: rtl/vec_dot_acc.sv
module vec_dot_acc
    import vdp_pkg::*;
#(
    parameter int unsigned LANES = 16,
    localparam int unsigned VEC_W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    input  logic [VEC_W-1:0] acc_in,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_result
);
    typedef struct packed {
        logic                              s1_vld;
        logic [LANES-1:0][DOT_W-1:0]       s1_dot;
        logic [LANES-1:0][LANE_W-1:0]      s1_acc;
        logic                              out_vld;
        logic [LANES-1:0][LANE_W-1:0]      out_res;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [LANES-1:0][DOT_W-1:0] lane_dot;
    logic advance, take, s1_vld_d, out_vld_d;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vdp_lane_dot u_dot (
            .mode (in_mode),
            .op_a (src_a[LANE_W*i +: LANE_W]),
            .op_b (src_b[LANE_W*i +: LANE_W]),
            .dot  (lane_dot[i])
        );
    end

    vdp_pipe_ctrl u_ctrl (
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .s1_vld_q  (pipe_q.s1_vld),
        .out_vld_q (pipe_q.out_vld),
        .advance   (advance),
        .take      (take),
        .s1_vld_d  (s1_vld_d),
        .out_vld_d (out_vld_d)
    );

    always_comb begin
        pipe_d         = pipe_q;
        pipe_d.s1_vld  = s1_vld_d;
        pipe_d.out_vld = out_vld_d;
        if (take) begin
            pipe_d.s1_dot = lane_dot;
            pipe_d.s1_acc = acc_in;
        end
        if (advance && pipe_q.s1_vld) begin
            for (int i = 0; i < int'(LANES); i++) begin
                pipe_d.out_res[i] = pipe_q.s1_acc[i] + pipe_q.s1_dot[i][LANE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign in_ready   = advance;
    assign out_valid  = pipe_q.out_vld;
    assign out_result = pipe_q.out_res;
endmodule

// File: rtl/vdp_chk.sv
module vdp_chk #(
    parameter int unsigned VEC_W = 512
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic             out_valid,
    input logic             out_ready,
    input logic [VEC_W-1:0] out_result
);
    // R7: accepted, then pipeline advances one more time -> result present
    a_r7_two_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) ##1 in_ready |=> out_valid);

    // R8: stalled output holds value and validity
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_result)));

    // R8: input refused while output stalled
    a_r8_block: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    // R1: empty output never blocks input
    a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    // R7: a fresh result stems from an operation taken two cycles earlier
    a_r7_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> $past(in_valid && in_ready, 2));
endmodule

bind vec_dot_acc vdp_chk #(.VEC_W(VEC_W)) u_vdp_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_result (out_result)
);

// File: tb/test_vec_dot_acc.sv
module test_vec_dot_acc;
    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 16;
    localparam int VEC_W      = LANES * 32;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid, in_ready, in_mode;
    logic [VEC_W-1:0] src_a, src_b, acc_in;
    logic             out_valid, out_ready;
    logic [VEC_W-1:0] out_result;

    always #(CLK_PERIOD/2) clk = ~clk;

    vec_dot_acc #(.LANES(LANES)) i_vec_dot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mode(in_mode), .src_a(src_a), .src_b(src_b), .acc_in(acc_in),
        .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
    );

    typedef struct {
        logic [VEC_W-1:0] res;
        string            tag;
        int               cyc;
        bit               lat;
    } exp_t;

    exp_t             q[$];
    int               checks = 0;
    int               errors = 0;
    int               cyc    = 0;
    bit               lat_mode = 1'b1;
    bit               bp_rand  = 1'b0;
    bit               prev_stall = 1'b0;
    logic [VEC_W-1:0] prev_res;

    function automatic logic [31:0] ref_lane(logic m, logic [31:0] a, logic [31:0] b, logic [31:0] c);
        longint s = longint'(c);
        if (!m) begin
            for (int k = 0; k < 4; k++)
                s += longint'({1'b0, a[8*k +: 8]}) * longint'($signed(b[8*k +: 8]));
        end else begin
            for (int k = 0; k < 2; k++)
                s += longint'($signed(a[16*k +: 16])) * longint'($signed(b[16*k +: 16]));
        end
        return s[31:0];
    endfunction

    function automatic logic [VEC_W-1:0] ref_vec(logic m, logic [VEC_W-1:0] a, logic [VEC_W-1:0] b, logic [VEC_W-1:0] c);
        logic [VEC_W-1:0] r;
        for (int i = 0; i < LANES; i++)
            r[32*i +: 32] = ref_lane(m, a[32*i +: 32], b[32*i +: 32], c[32*i +: 32]);
        return r;
    endfunction

    function automatic logic [VEC_W-1:0] rnd_vec();
        logic [VEC_W-1:0] v;
        for (int i = 0; i < LANES; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // evaluate one cycle: called just after a falling edge with inputs set
    task automatic step(output bit fired);
        if (bp_rand) out_ready = ($urandom % 4) != 0;
        #1;
        if (prev_stall) begin
            chk("R8 stalled output held", {out_result[VEC_W-2:0], out_valid}, {prev_res[VEC_W-2:0], 1'b1});
        end
        fired = in_valid && in_ready;
        if (fired) begin
            exp_t e;
            e.res = ref_vec(in_mode, src_a, src_b, acc_in);
            e.tag = "";
            e.cyc = cyc;
            e.lat = lat_mode;
            q.push_back(e);
        end
        if (out_valid && out_ready) begin
            if (q.size() == 0) begin
                chk("R8 unexpected result", VEC_W'(1), VEC_W'(0));
            end else begin
                exp_t e = q.pop_front();
                chk("R2 R3 R6 R9 lane values", out_result, e.res);
                if (e.lat) chk("R7 latency", VEC_W'(cyc - e.cyc), VEC_W'(2));
            end
        end
        prev_stall = out_valid && !out_ready;
        if (prev_stall) begin
            chk("R8 in_ready low in stall", VEC_W'(in_ready), VEC_W'(0));
        end
        prev_res = out_result;
        @(negedge clk);
        cyc++;
    endtask

    task automatic send(input logic m, input logic [VEC_W-1:0] a, b, c);
        bit f;
        in_valid = 1'b1; in_mode = m; src_a = a; src_b = b; acc_in = c;
        do step(f); while (!f);
        in_valid = 1'b0;
    endtask

    task automatic send_tagged(input string tag, input logic m, input logic [VEC_W-1:0] a, b, c,
                               input logic [31:0] lane_exp);
        // direct check of the expected value against the requirement arithmetic
        chk(tag, VEC_W'(ref_lane(m, a[31:0], b[31:0], c[31:0])), VEC_W'(lane_exp));
        send(m, a, b, c);
    endtask

    task automatic drain();
        bit f;
        bp_rand = 1'b0; out_ready = 1'b1; in_valid = 1'b0;
        for (int i = 0; i < 20 && q.size() != 0; i++) step(f);
        step(f); step(f);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit f;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 1'b0; out_ready = 1'b1;
        src_a = '0; src_b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        chk("R1 reset out_valid/in_ready", VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset out_valid/in_ready", VEC_W'({out_valid, in_ready}), VEC_W'(2'b01));

        // R4 byte extremes: 255 * -128 in all slots
        send_tagged("R4 byte extremes", 1'b0, {LANES{32'hFFFF_FFFF}}, {LANES{32'h8080_8080}},
                    '0, 32'hFFFE_0200);
        // R4 halfword extremes: -32768 * -32768 twice -> 2^31 wraps
        send_tagged("R4 halfword extremes", 1'b1, {LANES{32'h8000_8000}}, {LANES{32'h8000_8000}},
                    '0, 32'h8000_0000);
        send_tagged("R5 halfword extremes acc -1", 1'b1, {LANES{32'h8000_8000}}, {LANES{32'h8000_8000}},
                    {LANES{32'hFFFF_FFFF}}, 32'h7FFF_FFFF);
        // R5 wrap near positive limit
        send_tagged("R5 positive wrap", 1'b0, {LANES{32'h0101_0101}}, {LANES{32'h7F7F_7F7F}},
                    {LANES{32'h7FFF_FFF0}}, 32'h8000_01EC);
        // R5 wrap near negative limit
        send_tagged("R5 negative wrap", 1'b0, {LANES{32'hFFFF_FFFF}}, {LANES{32'h8080_8080}},
                    {LANES{32'h8000_0005}}, 32'h7FFE_0205);
        // R6 only lane 5 active
        begin
            logic [VEC_W-1:0] a1 = '0;
            a1[32*5 +: 32] = 32'h0403_0201;
            send(1'b0, a1, {LANES{32'h0101_0101}}, '0);
        end
        // R9 alternating modes back to back
        for (int i = 0; i < 12; i++) begin
            in_valid = 1'b1; in_mode = i[0]; src_a = rnd_vec(); src_b = rnd_vec(); acc_in = rnd_vec();
            step(f);
        end
        in_valid = 1'b0;
        drain();

        // R7 random stream, consumer always ready
        for (int i = 0; i < 200; i++) begin
            in_valid = ($urandom % 5) != 0; in_mode = $urandom % 2;
            src_a = rnd_vec(); src_b = rnd_vec();
            acc_in = (i % 7 == 0) ? {LANES{32'h7FFF_FF00 ^ ($urandom % 2 ? 32'hFFFF_FFFF : 32'h0)}} : rnd_vec();
            step(f);
        end
        drain();

        // R8 random back-pressure
        lat_mode = 1'b0; bp_rand = 1'b1;
        for (int i = 0; i < 400; i++) begin
            in_valid = ($urandom % 4) != 0; in_mode = $urandom % 2;
            src_a = rnd_vec(); src_b = rnd_vec(); acc_in = rnd_vec();
            step(f);
        end
        drain();
        chk("R8 no result lost", VEC_W'(q.size()), VEC_W'(0));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule